// File: doc/BRIEF.md
# Unrolled Multi-Step LFSR / CRC Stepper

This block advances a linear-feedback shift register by many serial shifts in one clock cycle. A purely combinational core takes the present register state and a word of input bits and returns two things: the state reached after one shift per input bit, and the serial output bit produced by each of those shifts. Parameters set the register width, the feedback tap mask, the feedback topology and the bit order. The topology is either Galois, the usual choice for CRC generation and checking, or Fibonacci, the usual choice for PRBS generators and scramblers. The bit order is either MSB-first or bit-reversed, which is LSB-first.

The tap mask leaves out the highest-order term of the polynomial, because the register width already implies it. For example, a 16-bit register with x^16+x^15+x^2+1 takes the mask 0x8005. If the data word is held at zero, each evaluation moves a free-running sequence forward by STEP_N positions.

The top level wraps the core in a state register. A synchronous reset loads a seed, which is all ones by default. A data-valid enable gates each update, and an optional bitwise inversion is applied to the register's output. With the default parameters the wrapper computes the common reflected, inverted 32-bit CRC one byte per cycle.

Top module: `lfsr_stepper`

## Requirements
- R1: Galois shift (FEED=1), one data bit d: fb = s[W-1] ^ d. Then s'[0] = fb, and for i >= 1, s'[i] = s[i-1] ^ (TAP_MASK[i] & fb). The output bit of that shift is s[W-1] taken before the shift. TAP_MASK[0] is not used, because the register's bit 0 always takes fb.
- R2: Fibonacci shift (FEED=0), one data bit d: fb = d ^ s[W-1] ^ (XOR over every j >= 1 with TAP_MASK[j]=1 of s[j-1]). Then s' = {s[W-2:0], fb}, and the output bit of that shift is fb.
- R3: A data word of STEP_N bits performs exactly STEP_N shifts in one evaluation. With BIT_REV=0, data bit STEP_N-1 is consumed first, and the output bit of shift k (k=0 is the first) appears at step_bits position STEP_N-1-k.
- R4: With BIT_REV=1, the state is bit-reversed on the way into the shift chain and again on the way out. Data bit 0 is consumed first, and the output bit of shift k appears at position k.
- R5: With the data word held at zero, repeated evaluations walk the free-running sequence. For a maximal-length 7-bit register advanced 4 shifts per evaluation, the state first returns to its starting value after exactly 127 evaluations.
- R6: The registered state loads SEED on a rising clock edge while rst is high, whatever din_vld is. The default SEED is all ones.
- R7: When rst is low, the registered state takes the core's next state on an edge where din_vld is high, and keeps its value when din_vld is low.
- R8: With OUT_INV=1, crc_out is the bitwise inverse of the registered state. With OUT_INV=0, crc_out is the state itself.
- R9: With the defaults (32 bits, mask 0x04C11DB7, Galois, BIT_REV=1, seed all ones, OUT_INV=1, STEP_N=8), feeding the nine ASCII bytes "123456789" gives crc_out = 0xCBF43926.
- R10: step_bits is combinational. It gives the serial output bits of the shifts that the current registered state and the current din would produce, in the order set by R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset; loads SEED |
| din | input | STEP_N | Data bits shifted in during one evaluation |
| din_vld | input | 1 | Enables the state update on this edge |
| crc_out | output | STATE_W | Registered state, inverted when OUT_INV=1 |
| step_bits | output | STEP_N | Serial output bits of the pending shifts |

## Verification
The core is swept over every state and data combination in four small configurations, one for each pairing of Galois or Fibonacci feedback with MSB-first or LSB-first order. A mistake in the tap alignment, the feedback term, the bit order or the output-bit placement therefore appears as a mismatch against a bench model that shifts one bit at a time. An all-zero data walk over a maximal-length 7-bit register separates correct multi-step advance from a wrong step count, because any error shortens or breaks the period of 127. The 32-bit wrapper is driven with the "123456789" check string, with a pseudo-random byte stream that has idle gaps, and with reset asserted while valid is high. These runs separate the reflected byte ordering, enable gating and reset priority.

// File: rtl/lfsr_step_pkg.sv
package lfsr_step_pkg;

   // Feedback topology of the shift register
   typedef enum logic {
      FEED_FIB = 1'b0,  // taps summed into bit 0, PRBS style
      FEED_GAL = 1'b1   // feedback XORed into tapped stages, CRC style
   } feed_e;

endpackage

// File: rtl/lfsr_bitrev.sv
module lfsr_bitrev #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   output logic [W-1:0] y_o
);

   if (W < 1) begin : g_bad_w
      $error("lfsr_bitrev: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_flip
      assign y_o[i] = a_i[W-1-i];
   end

endmodule

// File: rtl/lfsr_galois_chain.sv
module lfsr_galois_chain #(
   parameter int           W    = 32,
   parameter logic [W-1:0] POLY = '0,
   parameter int           N    = 8
) (
   input  logic [W-1:0] st_i,
   input  logic [N-1:0] dat_i,
   output logic [W-1:0] st_o,
   output logic [N-1:0] bit_o
);

   // bit 0 always takes the feedback, so the mask's own bit 0 is not used
   localparam logic [W-1:0] TAPS = {POLY[W-1:1], 1'b0};

   logic [W-1:0] s;
   logic         fb;

   always_comb begin
      s     = st_i;
      fb    = 1'b0;
      bit_o = '0;
      for (int k = 0; k < N; k++) begin
         bit_o[N-1-k] = s[W-1];
         fb           = s[W-1] ^ dat_i[N-1-k];
         s            = {s[W-2:0], fb} ^ (TAPS & {W{fb}});
      end
      st_o = s;
      // R1: the all-zero state with all-zero data stays at zero
      p_gal_zero_r1: assert ((st_i != '0) || (dat_i != '0) || (st_o == '0))
         else $error("galois chain left the zero state");
   end

endmodule

// File: rtl/lfsr_fib_chain.sv
module lfsr_fib_chain #(
   parameter int           W    = 32,
   parameter logic [W-1:0] POLY = '0,
   parameter int           N    = 8
) (
   input  logic [W-1:0] st_i,
   input  logic [N-1:0] dat_i,
   output logic [W-1:0] st_o,
   output logic [N-1:0] bit_o
);

   // mask bit j taps register bit j-1; the top bit is always tapped
   localparam logic [W-2:0] TAPS = POLY[W-1:1];

   logic [W-1:0] s;
   logic         fb;

   always_comb begin
      s     = st_i;
      fb    = 1'b0;
      bit_o = '0;
      for (int k = 0; k < N; k++) begin
         fb           = dat_i[N-1-k] ^ s[W-1] ^ (^(s[W-2:0] & TAPS));
         bit_o[N-1-k] = fb;
         s            = {s[W-2:0], fb};
      end
      st_o = s;
      // R2: every emitted bit also entered the register at bit 0
      for (int k = 0; k < N && k < W; k++) begin
         p_fib_emit_r2: assert (st_o[k] == bit_o[k])
            else $error("fibonacci output bit %0d not in state", k);
      end
      // R2: the untouched upper part is the old state moved up by N
      for (int i = N; i < W; i++) begin
         p_fib_shift_r2: assert (st_o[i] == st_i[i-N])
            else $error("fibonacci state bit %0d not shifted", i);
      end
   end

endmodule

// File: rtl/lfsr_step_core.sv
module lfsr_step_core
   import lfsr_step_pkg::*;
#(
   parameter int                 STATE_W  = 32,
   parameter logic [STATE_W-1:0] TAP_MASK = 32'h04C1_1DB7,
   parameter feed_e              FEED     = FEED_GAL,
   parameter bit                 BIT_REV  = 1'b1,
   parameter int                 STEP_N   = 8
) (
   input  logic [STATE_W-1:0] st_i,
   input  logic [STEP_N-1:0]  dat_i,
   output logic [STATE_W-1:0] st_o,
   output logic [STEP_N-1:0]  bit_o
);

   if (STATE_W < 2) begin : g_bad_w
      $error("lfsr_step_core: STATE_W must be at least 2");
   end
   if (STEP_N < 1) begin : g_bad_n
      $error("lfsr_step_core: STEP_N must be at least 1");
   end

   logic [STATE_W-1:0] ch_st_in;
   logic [STATE_W-1:0] ch_st_out;
   logic [STEP_N-1:0]  ch_dat;
   logic [STEP_N-1:0]  ch_bits;

   // bit order: reversed operation flips state, data and emitted bits
   if (BIT_REV) begin : g_rev
      lfsr_bitrev #(.W(STATE_W)) u_rev_st_in  (.a_i(st_i),      .y_o(ch_st_in));
      lfsr_bitrev #(.W(STEP_N))  u_rev_dat    (.a_i(dat_i),     .y_o(ch_dat));
      lfsr_bitrev #(.W(STATE_W)) u_rev_st_out (.a_i(ch_st_out), .y_o(st_o));
      lfsr_bitrev #(.W(STEP_N))  u_rev_bits   (.a_i(ch_bits),   .y_o(bit_o));
   end else begin : g_fwd
      assign ch_st_in = st_i;
      assign ch_dat   = dat_i;
      assign st_o     = ch_st_out;
      assign bit_o    = ch_bits;
   end

   // topology
   if (FEED == FEED_GAL) begin : g_gal
      lfsr_galois_chain #(
         .W(STATE_W), .POLY(TAP_MASK), .N(STEP_N)
      ) u_chain (
         .st_i(ch_st_in), .dat_i(ch_dat), .st_o(ch_st_out), .bit_o(ch_bits)
      );
   end else begin : g_fib
      lfsr_fib_chain #(
         .W(STATE_W), .POLY(TAP_MASK), .N(STEP_N)
      ) u_chain (
         .st_i(ch_st_in), .dat_i(ch_dat), .st_o(ch_st_out), .bit_o(ch_bits)
      );
   end

endmodule

// File: rtl/lfsr_stepper.sv
module lfsr_stepper
   import lfsr_step_pkg::*;
#(
   parameter int                 STATE_W  = 32,
   parameter logic [STATE_W-1:0] TAP_MASK = 32'h04C1_1DB7,
   parameter logic [STATE_W-1:0] SEED     = '1,
   parameter feed_e              FEED     = FEED_GAL,
   parameter bit                 BIT_REV  = 1'b1,
   parameter bit                 OUT_INV  = 1'b1,
   parameter int                 STEP_N   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STEP_N-1:0]  din,
   input  logic               din_vld,
   output logic [STATE_W-1:0] crc_out,
   output logic [STEP_N-1:0]  step_bits
);

   logic [STATE_W-1:0] st_q;
   logic [STATE_W-1:0] st_nxt;

   lfsr_step_core #(
      .STATE_W(STATE_W), .TAP_MASK(TAP_MASK), .FEED(FEED),
      .BIT_REV(BIT_REV), .STEP_N(STEP_N)
   ) u_core (
      .st_i(st_q), .dat_i(din), .st_o(st_nxt), .bit_o(step_bits)
   );

   // reset wins over the valid enable
   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= SEED;
      end else if (din_vld) begin
         st_q <= st_nxt;
      end
   end

   if (OUT_INV) begin : g_inv
      assign crc_out = ~st_q;
   end else begin : g_plain
      assign crc_out = st_q;
   end

   // R6: reset loads the seed even with valid high
   p_reset_load_r6: assert property (@(posedge clk)
      rst |=> (st_q == SEED))
      else $error("state not seeded after reset");

   // R7: idle cycles keep the state
   p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> $stable(st_q))
      else $error("state moved without valid");

endmodule

// File: tb/lfsr_stepper_bench.sv
module lfsr_stepper_bench;
   import lfsr_step_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  din;
   logic        din_vld;
   logic [31:0] crc_out;
   logic [7:0]  step_bits;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_stepper u_lfsr_stepper (
      .clk(clk), .rst(rst), .din(din), .din_vld(din_vld),
      .crc_out(crc_out), .step_bits(step_bits)
   );

   // small cores for exhaustive sweeps
   logic [6:0] c1_si, c1_so; logic [3:0] c1_di, c1_bo;  // fib, msb first
   logic [5:0] c2_si, c2_so; logic [2:0] c2_di, c2_bo;  // galois, lsb first
   logic [7:0] c3_si, c3_so; logic [4:0] c3_di, c3_bo;  // galois, msb first
   logic [4:0] c4_si, c4_so; logic [2:0] c4_di, c4_bo;  // fib, lsb first

   lfsr_step_core #(.STATE_W(7), .TAP_MASK(7'h41), .FEED(FEED_FIB), .BIT_REV(1'b0), .STEP_N(4))
      u_c1 (.st_i(c1_si), .dat_i(c1_di), .st_o(c1_so), .bit_o(c1_bo));
   lfsr_step_core #(.STATE_W(6), .TAP_MASK(6'h03), .FEED(FEED_GAL), .BIT_REV(1'b1), .STEP_N(3))
      u_c2 (.st_i(c2_si), .dat_i(c2_di), .st_o(c2_so), .bit_o(c2_bo));
   lfsr_step_core #(.STATE_W(8), .TAP_MASK(8'h07), .FEED(FEED_GAL), .BIT_REV(1'b0), .STEP_N(5))
      u_c3 (.st_i(c3_si), .dat_i(c3_di), .st_o(c3_so), .bit_o(c3_bo));
   lfsr_step_core #(.STATE_W(5), .TAP_MASK(5'h05), .FEED(FEED_FIB), .BIT_REV(1'b1), .STEP_N(3))
      u_c4 (.st_i(c4_si), .dat_i(c4_di), .st_o(c4_so), .bit_o(c4_bo));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] flip(input logic [63:0] x, input int w);
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = x[w-1-i];
      return r;
   endfunction

   // one-bit-at-a-time model of R1..R4
   function automatic logic [63:0] ref_step(input logic [63:0] s_in, input logic [63:0] d,
                                            input int w, input logic [63:0] poly, input bit gal,
                                            input bit rev, input int n, output logic [63:0] bits);
      logic [63:0] s, mask;
      logic db, fb, ob;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      s    = rev ? flip(s_in, w) : s_in;
      bits = '0;
      for (int k = 0; k < n; k++) begin
         db = rev ? d[k] : d[n-1-k];
         if (gal) begin
            ob = s[w-1];
            fb = s[w-1] ^ db;
            s  = (s << 1) | 64'(fb);
            if (fb) s = s ^ (poly & ~64'd1);
         end else begin
            fb = db ^ s[w-1];
            for (int j = 1; j < w; j++) if (poly[j]) fb = fb ^ s[j-1];
            ob = fb;
            s  = (s << 1) | 64'(fb);
         end
         s = s & mask;
         bits[rev ? k : n-1-k] = ob;
      end
      return rev ? flip(s, w) : s;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [63:0] ref_s, exp, eb;
      logic [31:0] held;
      logic [7:0]  prng;
      string       msg;

      rst = 1'b1; din = '0; din_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      ref_s = 64'hFFFF_FFFF;

      // R6 / R8: seed is all ones, output inverted to zero
      chk(crc_out == 32'h0, "R6 R8 reset state", 64'(crc_out), 64'h0);
      // R10: bits for pending shifts visible combinationally
      din = 8'h00; #1;
      void'(ref_step(ref_s, 64'h00, 32, 64'h04C11DB7, 1, 1, 8, eb));
      chk(step_bits == eb[7:0], "R10 step_bits at reset", 64'(step_bits), eb);

      // R9: check string
      msg = "123456789";
      for (int i = 0; i < 9; i++) begin
         din = msg[i]; #1;
         exp = ref_step(ref_s, 64'(msg[i]), 32, 64'h04C11DB7, 1, 1, 8, eb);
         chk(step_bits == eb[7:0], "R10 R4 step_bits", 64'(step_bits), eb);
         din_vld = 1'b1;
         @(negedge clk);
         din_vld = 1'b0;
         ref_s = exp;
         chk(crc_out == ~ref_s[31:0], "R4 R8 running crc", 64'(crc_out), 64'(~ref_s[31:0]));
      end
      chk(crc_out == 32'hCBF43926, "R9 check value", 64'(crc_out), 64'hCBF43926);

      // R7: no update without valid
      held = crc_out;
      for (int i = 0; i < 5; i++) begin
         din = 8'(8'h3C + 8'(i * 37));
         @(negedge clk);
         chk(crc_out == held, "R7 hold without valid", 64'(crc_out), 64'(held));
      end

      // R6: reset beats valid
      din = 8'hA5; din_vld = 1'b1; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; din_vld = 1'b0;
      chk(crc_out == 32'h0, "R6 reset priority", 64'(crc_out), 64'h0);
      ref_s = 64'hFFFF_FFFF;

      // R3 / R7: pseudo-random stream with idle gaps
      prng = 8'h5B;
      for (int i = 0; i < 200; i++) begin
         prng = {prng[6:0], prng[7] ^ prng[5] ^ prng[4] ^ prng[3]};
         din = prng;
         din_vld = (i % 3) != 2;
         exp = ref_step(ref_s, 64'(prng), 32, 64'h04C11DB7, 1, 1, 8, eb);
         @(negedge clk);
         if (din_vld) ref_s = exp;
         chk(crc_out == ~ref_s[31:0], "R3 R7 stream", 64'(crc_out), 64'(~ref_s[31:0]));
      end
      din_vld = 1'b0;

      // R2 R3: fibonacci, msb first, exhaustive
      for (int st = 0; st < 128; st++) begin
         for (int d = 0; d < 16; d++) begin
            c1_si = 7'(st); c1_di = 4'(d); #1;
            exp = ref_step(64'(st), 64'(d), 7, 64'h41, 0, 0, 4, eb);
            chk(c1_so == exp[6:0] && c1_bo == eb[3:0], "R2 R3 fib msb",
                64'({c1_so, c1_bo}), 64'({exp[6:0], eb[3:0]}));
         end
      end
      // R1 R4: galois, lsb first, exhaustive
      for (int st = 0; st < 64; st++) begin
         for (int d = 0; d < 8; d++) begin
            c2_si = 6'(st); c2_di = 3'(d); #1;
            exp = ref_step(64'(st), 64'(d), 6, 64'h03, 1, 1, 3, eb);
            chk(c2_so == exp[5:0] && c2_bo == eb[2:0], "R1 R4 gal lsb",
                64'({c2_so, c2_bo}), 64'({exp[5:0], eb[2:0]}));
         end
      end
      // R1 R3: galois, msb first, exhaustive
      for (int st = 0; st < 256; st++) begin
         for (int d = 0; d < 32; d++) begin
            c3_si = 8'(st); c3_di = 5'(d); #1;
            exp = ref_step(64'(st), 64'(d), 8, 64'h07, 1, 0, 5, eb);
            chk(c3_so == exp[7:0] && c3_bo == eb[4:0], "R1 R3 gal msb",
                64'({c3_so, c3_bo}), 64'({exp[7:0], eb[4:0]}));
         end
      end
      // R2 R4: fibonacci, lsb first, exhaustive
      for (int st = 0; st < 32; st++) begin
         for (int d = 0; d < 8; d++) begin
            c4_si = 5'(st); c4_di = 3'(d); #1;
            exp = ref_step(64'(st), 64'(d), 5, 64'h05, 0, 1, 3, eb);
            chk(c4_so == exp[4:0] && c4_bo == eb[2:0], "R2 R4 fib lsb",
                64'({c4_so, c4_bo}), 64'({exp[4:0], eb[2:0]}));
         end
      end

      // R5: zero-data free run, first return after 127 evaluations
      begin
         int first_ret = 0;
         logic [6:0] cur = 7'h01;
         c1_di = 4'h0;
         for (int i = 1; i <= 130; i++) begin
            c1_si = cur; #1;
            cur = c1_so;
            if (cur == 7'h01 && first_ret == 0) first_ret = i;
         end
         chk(first_ret == 127, "R5 free-run period", 64'(first_ret), 64'd127);
      end

      finish_run();
   end

endmodule